// File: doc/BRIEF.md
# Pixel Output Formatter with Range Clamp

This block sits at the end of a display pixel pipeline and shapes a stream of 36-bit pixels for a parallel output bus. Each pixel holds three 12-bit channels and comes with a data-enable strobe. The block can exchange the first and third input channels and limit luma and chroma to programmable ranges. It can also permute the channels, reduce luma/chroma data to 4:2:2 and place luma and chroma on chosen output lanes. Each lane is then cut or padded to the selected output depth.

The block is a fixed three-stage pipeline with no back-pressure. Configuration is read from static inputs and should be held steady while a line streams. The swap and clamp happen in the first stage, ordering and chroma subsampling in the second, and lane placement and depth fitting in the third. The output carries three 16-bit lanes.

Input channel k (k = 0, 1, 2) sits in `pix_i[(2-k)*12 +: 12]`. Output lane k sits in `pix_o[(2-k)*16 +: 16]`. The format code `fmt_i` is 0 for RGB, 1 for luma/chroma 4:4:4, 2 for luma/chroma 4:2:2 and 3 for RGB.

Top module: `pix_fmt_out`

## Requirements
- R1: While `rst_ni` is low, `vld_o` and `pix_o` are 0, whatever is driven on the inputs.
- R2: `vld_o` equals `vld_i` delayed by exactly 3 clocks. `pix_o` is all zero in any cycle where `vld_o` is 0.
- R3: With `fmt_i` 0 or 3, no clamping takes place. If `rb_swap_i` is 1, input channels 0 and 2 are exchanged before any other step. The order is then taken from `order_i`.
- R4: The order code `order_i` sets which post-swap channels (a,b,c) feed positions 0,1,2: 0=(0,1,2), 1=(1,2,0), 2=(2,0,1), 3=(0,2,1), 4=(1,0,2), 5=(2,1,0). Codes 6 and 7 act as 0.
- R5: With `fmt_i` 1 or 2, each post-swap channel is clamped. Channel 1 is limited by `y_lo_i`/`y_hi_i`, and channels 0 and 2 by `c_lo_i`/`c_hi_i`. A value below the low limit becomes the low limit, and a value above the high limit becomes the high limit.
- R6: With `fmt_i`=1, the swap is forced off and the order is forced to code 5. `rb_swap_i` and `order_i` have no effect.
- R7: With `fmt_i`=2, the swap is forced on and the order is forced to code 0. Luma Y is position 1. Chroma C is position 2 on even pixels and position 0 on odd pixels. In all other formats Y is position 1 and C is position 0.
- R8: The lane map code `lane_map_i` sets lanes 0,1,2 as follows: 0=(pos0,pos1,pos2); 1 = (C,Y,0) on even and (Y,C,0) on odd pixels; 2 = (Y,C,0) on even and (C,Y,0) on odd pixels; 3=(C,Y,0); 4=(Y,C,0). Codes 5 to 7 act as 0.
- R9: The depth code `depth_i` sets how each 12-bit value v fills its 16-bit lane. 0 gives v[11:4] in the low 8 bits. 1 gives v[11:2] in the low 10 bits. 2 gives v in the low 12 bits. 3 gives v shifted left by 4. Codes 4 to 7 act as 0. Unused lane bits are 0.
- R10: Pixel parity counts valid pixels from 0 (even). The count restarts at the first valid pixel after `vld_i` has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input data enable |
| pix_i | input | 36 | Input pixel, three 12-bit channels |
| fmt_i | input | 2 | Format: 0/3 RGB, 1 luma/chroma 4:4:4, 2 luma/chroma 4:2:2 |
| rb_swap_i | input | 1 | Exchange input channels 0 and 2 (RGB formats) |
| order_i | input | 3 | Channel order code (RGB formats) |
| lane_map_i | input | 3 | Luma/chroma lane map code |
| depth_i | input | 3 | Output depth code |
| y_lo_i | input | 12 | Luma low limit |
| y_hi_i | input | 12 | Luma high limit |
| c_lo_i | input | 12 | Chroma low limit |
| c_hi_i | input | 12 | Chroma high limit |
| vld_o | output | 1 | Output data enable |
| pix_o | output | 48 | Output pixel, three 16-bit lanes |

## Verification
The hardest case to reach from the ports is the restart of the 4:2:2 chroma parity. This needs an odd-length burst followed by a gap and then a new burst. If the parity were not restarted, the second burst would begin on an odd pixel and pick the wrong chroma sample. The bench therefore sends a five-pixel burst and then a four-pixel burst in 4:2:2 mode with a per-pixel alternating lane map, so that any parity slip changes both lane placement and chroma choice. Forced overrides are shown by driving `rb_swap_i` and `order_i` to values that would change the result if they were honoured.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;
  localparam int LANE_W = 16;

  typedef enum logic [1:0] {
    FMT_RGB  = 2'd0,
    FMT_Y444 = 2'd1,
    FMT_Y422 = 2'd2,
    FMT_ALT  = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    ORD_RGB = 3'd0,
    ORD_GBR = 3'd1,
    ORD_BRG = 3'd2,
    ORD_RBG = 3'd3,
    ORD_GRB = 3'd4,
    ORD_BGR = 3'd5
  } ord_e;

  typedef enum logic [2:0] {
    MAP_PASS = 3'd0,
    MAP_CYCY = 3'd1,
    MAP_YCYC = 3'd2,
    MAP_CY   = 3'd3,
    MAP_YC   = 3'd4
  } map_e;

  typedef enum logic [2:0] {
    DEP_8  = 3'd0,
    DEP_10 = 3'd1,
    DEP_12 = 3'd2,
    DEP_16 = 3'd3
  } dep_e;

  function automatic logic is_ycc(input logic [1:0] f);
    return (f == FMT_Y444) || (f == FMT_Y422);
  endfunction
endpackage

// File: rtl/pix_fmt_clamp.sv
module pix_fmt_clamp
  import pix_fmt_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic [2:0][CW-1:0]   ch_i,
  input  logic [1:0]           fmt_i,
  input  logic                 rb_swap_i,
  input  logic [CW-1:0]        y_lo_i,
  input  logic [CW-1:0]        y_hi_i,
  input  logic [CW-1:0]        c_lo_i,
  input  logic [CW-1:0]        c_hi_i,
  output logic                 vld_o,
  output logic                 par_o,
  output logic [2:0][CW-1:0]   ch_o
);
  logic              swap_en;
  logic              clamp_en;
  logic [2:0][CW-1:0] sw;
  logic [2:0][CW-1:0] cl;
  logic              prev_vld;
  logic              nxt_par;

  always_comb begin
    unique case (fmt_i)
      FMT_Y422: swap_en = 1'b1;
      FMT_Y444: swap_en = 1'b0;
      default:  swap_en = rb_swap_i;
    endcase
  end

  assign clamp_en = is_ycc(fmt_i);
  assign sw[0] = swap_en ? ch_i[2] : ch_i[0];
  assign sw[1] = ch_i[1];
  assign sw[2] = swap_en ? ch_i[0] : ch_i[2];

  for (genvar k = 0; k < 3; k++) begin : g_clamp
    localparam bit IS_Y = (k == 1);
    logic [CW-1:0] lo, hi, v;
    assign lo = IS_Y ? y_lo_i : c_lo_i;
    assign hi = IS_Y ? y_hi_i : c_hi_i;
    always_comb begin
      if (!clamp_en)       v = sw[k];
      else if (sw[k] < lo) v = lo;
      else if (sw[k] > hi) v = hi;
      else                 v = sw[k];
    end
    assign cl[k] = v;
  end

  // parity restarts at the first valid pixel after a gap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o    <= 1'b0;
      par_o    <= 1'b0;
      ch_o     <= '0;
      prev_vld <= 1'b0;
      nxt_par  <= 1'b0;
    end else begin
      vld_o    <= vld_i;
      ch_o     <= cl;
      prev_vld <= vld_i;
      if (vld_i) begin
        par_o   <= prev_vld ? nxt_par : 1'b0;
        nxt_par <= prev_vld ? ~nxt_par : 1'b1;
      end
    end
  end
endmodule

// File: rtl/pix_fmt_order.sv
module pix_fmt_order
  import pix_fmt_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 par_i,
  input  logic [2:0][CW-1:0]   ch_i,
  input  logic [1:0]           fmt_i,
  input  logic [2:0]           order_i,
  output logic                 vld_o,
  output logic                 par_o,
  output logic [2:0][CW-1:0]   p_o,
  output logic [CW-1:0]        y_o,
  output logic [CW-1:0]        c_o
);
  logic [2:0]         ord;
  logic [1:0]         s0, s1, s2;
  logic [2:0][CW-1:0] p;
  logic [CW-1:0]      c_sel;

  function automatic logic [CW-1:0] pick(input logic [2:0][CW-1:0] ch, input logic [1:0] s);
    unique case (s)
      2'd0:    return ch[0];
      2'd1:    return ch[1];
      default: return ch[2];
    endcase
  endfunction

  always_comb begin
    unique case (fmt_i)
      FMT_Y422: ord = ORD_RGB;
      FMT_Y444: ord = ORD_BGR;
      default:  ord = order_i;
    endcase
  end

  always_comb begin
    unique case (ord)
      ORD_GBR: {s0, s1, s2} = {2'd1, 2'd2, 2'd0};
      ORD_BRG: {s0, s1, s2} = {2'd2, 2'd0, 2'd1};
      ORD_RBG: {s0, s1, s2} = {2'd0, 2'd2, 2'd1};
      ORD_GRB: {s0, s1, s2} = {2'd1, 2'd0, 2'd2};
      ORD_BGR: {s0, s1, s2} = {2'd2, 2'd1, 2'd0};
      default: {s0, s1, s2} = {2'd0, 2'd1, 2'd2};
    endcase
  end

  assign p[0] = pick(ch_i, s0);
  assign p[1] = pick(ch_i, s1);
  assign p[2] = pick(ch_i, s2);

  // 4:2:2: even pixels carry position 2, odd pixels position 0
  assign c_sel = (fmt_i == FMT_Y422) ? (par_i ? p[0] : p[2]) : p[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      par_o <= 1'b0;
      p_o   <= '0;
      y_o   <= '0;
      c_o   <= '0;
    end else begin
      vld_o <= vld_i;
      par_o <= par_i;
      p_o   <= p;
      y_o   <= p[1];
      c_o   <= c_sel;
    end
  end
endmodule

// File: rtl/pix_fmt_lane.sv
module pix_fmt_lane
  import pix_fmt_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic                  par_i,
  input  logic [2:0][CW-1:0]    p_i,
  input  logic [CW-1:0]         y_i,
  input  logic [CW-1:0]         c_i,
  input  logic [2:0]            lane_map_i,
  input  logic [2:0]            depth_i,
  output logic                  vld_o,
  output logic [3*LANE_W-1:0]   pix_o
);
  logic [2:0][CW-1:0] ln;
  logic [3*LANE_W-1:0] fitted;

  function automatic logic [LANE_W-1:0] fit(input logic [CW-1:0] v, input logic [2:0] d);
    logic [LANE_W-1:0] e;
    e = LANE_W'(v);
    unique case (d)
      DEP_10:  return e >> (CW - 10);
      DEP_12:  return e >> (CW - 12);
      DEP_16:  return e << (LANE_W - CW);
      default: return e >> (CW - 8);
    endcase
  endfunction

  always_comb begin
    unique case (lane_map_i)
      MAP_CYCY: ln = par_i ? {{CW{1'b0}}, c_i, y_i} : {{CW{1'b0}}, y_i, c_i};
      MAP_YCYC: ln = par_i ? {{CW{1'b0}}, y_i, c_i} : {{CW{1'b0}}, c_i, y_i};
      MAP_CY:   ln = {{CW{1'b0}}, y_i, c_i};
      MAP_YC:   ln = {{CW{1'b0}}, c_i, y_i};
      default:  ln = p_i;
    endcase
  end

  for (genvar k = 0; k < 3; k++) begin : g_fit
    assign fitted[(2-k)*LANE_W +: LANE_W] = fit(ln[k], depth_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      pix_o <= '0;
    end else begin
      vld_o <= vld_i;
      pix_o <= vld_i ? fitted : '0;
    end
  end
endmodule

// File: rtl/pix_fmt_out.sv
module pix_fmt_out
  import pix_fmt_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic [3*CW-1:0]      pix_i,
  input  logic [1:0]           fmt_i,
  input  logic                 rb_swap_i,
  input  logic [2:0]           order_i,
  input  logic [2:0]           lane_map_i,
  input  logic [2:0]           depth_i,
  input  logic [CW-1:0]        y_lo_i,
  input  logic [CW-1:0]        y_hi_i,
  input  logic [CW-1:0]        c_lo_i,
  input  logic [CW-1:0]        c_hi_i,
  output logic                 vld_o,
  output logic [3*LANE_W-1:0]  pix_o
);
  logic [2:0][CW-1:0] ch_in;
  logic               s1_vld, s1_par;
  logic [2:0][CW-1:0] s1_ch;
  logic               s2_vld, s2_par;
  logic [2:0][CW-1:0] s2_p;
  logic [CW-1:0]      s2_y, s2_c;

  for (genvar k = 0; k < 3; k++) begin : g_unpack
    assign ch_in[k] = pix_i[(2-k)*CW +: CW];
  end

  pix_fmt_clamp #(.CW(CW)) u_clamp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (vld_i),
    .ch_i      (ch_in),
    .fmt_i     (fmt_i),
    .rb_swap_i (rb_swap_i),
    .y_lo_i    (y_lo_i),
    .y_hi_i    (y_hi_i),
    .c_lo_i    (c_lo_i),
    .c_hi_i    (c_hi_i),
    .vld_o     (s1_vld),
    .par_o     (s1_par),
    .ch_o      (s1_ch)
  );

  pix_fmt_order #(.CW(CW)) u_order (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (s1_vld),
    .par_i   (s1_par),
    .ch_i    (s1_ch),
    .fmt_i   (fmt_i),
    .order_i (order_i),
    .vld_o   (s2_vld),
    .par_o   (s2_par),
    .p_o     (s2_p),
    .y_o     (s2_y),
    .c_o     (s2_c)
  );

  pix_fmt_lane #(.CW(CW)) u_lane (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (s2_vld),
    .par_i      (s2_par),
    .p_i        (s2_p),
    .y_i        (s2_y),
    .c_i        (s2_c),
    .lane_map_i (lane_map_i),
    .depth_i    (depth_i),
    .vld_o      (vld_o),
    .pix_o      (pix_o)
  );
endmodule

// File: rtl/pix_fmt_out_chk.sv
module pix_fmt_out_chk
  import pix_fmt_pkg::*;
#(
  parameter int CW = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 vld_i,
  input logic [1:0]           fmt_i,
  input logic                 rb_swap_i,
  input logic [2:0]           order_i,
  input logic [2:0]           lane_map_i,
  input logic [2:0]           depth_i,
  input logic [CW-1:0]        y_lo_i,
  input logic [CW-1:0]        y_hi_i,
  input logic [CW-1:0]        c_lo_i,
  input logic [CW-1:0]        c_hi_i,
  input logic                 vld_o,
  input logic [3*LANE_W-1:0]  pix_o
);
  localparam int CFG_W = 12 + 4*CW;
  localparam int OW    = 3*LANE_W;

  logic [1:0]       cyc;
  logic [1:0]       quiet;
  logic [CFG_W-1:0] cfg, cfg_q;
  logic             steady;

  assign cfg = {fmt_i, rb_swap_i, order_i, lane_map_i, depth_i, y_lo_i, y_hi_i, c_lo_i, c_hi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc   <= '0;
      quiet <= '0;
      cfg_q <= '0;
    end else begin
      if (cyc != 2'd3) cyc <= cyc + 2'd1;
      cfg_q <= cfg;
      if (cfg != cfg_q) quiet <= '0;
      else if (quiet != 2'd3) quiet <= quiet + 2'd1;
    end
  end

  assign steady = (quiet == 2'd3) && (cfg == cfg_q);

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3) |-> (vld_o == $past(vld_i, 3)));

  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (pix_o == '0));

  a_r9_depth8_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && vld_o && (depth_i == DEP_8 || depth_i > DEP_16)) |->
      (pix_o[OW-1 -: LANE_W-8] == '0 && pix_o[2*LANE_W-1 -: LANE_W-8] == '0 &&
       pix_o[LANE_W-1 -: LANE_W-8] == '0));

  a_r8_lane2_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && vld_o && lane_map_i != MAP_PASS && lane_map_i <= MAP_YC) |->
      (pix_o[LANE_W-1:0] == '0));

  a_r5_clamp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steady && vld_o && is_ycc(fmt_i) && lane_map_i == MAP_PASS && depth_i == DEP_16 &&
     y_lo_i <= y_hi_i && c_lo_i <= c_hi_i) |->
      (pix_o[2*LANE_W-1 -: CW] >= y_lo_i && pix_o[2*LANE_W-1 -: CW] <= y_hi_i &&
       pix_o[OW-1 -: CW] >= c_lo_i && pix_o[OW-1 -: CW] <= c_hi_i &&
       pix_o[LANE_W-1 -: CW] >= c_lo_i && pix_o[LANE_W-1 -: CW] <= c_hi_i));
endmodule

bind pix_fmt_out pix_fmt_out_chk #(.CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vld_i      (vld_i),
  .fmt_i      (fmt_i),
  .rb_swap_i  (rb_swap_i),
  .order_i    (order_i),
  .lane_map_i (lane_map_i),
  .depth_i    (depth_i),
  .y_lo_i     (y_lo_i),
  .y_hi_i     (y_hi_i),
  .c_lo_i     (c_lo_i),
  .c_hi_i     (c_hi_i),
  .vld_o      (vld_o),
  .pix_o      (pix_o)
);

// File: tb/tb_pix_fmt_out.sv
module tb_pix_fmt_out;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_ni;
  logic        vld_i;
  logic [35:0] pix_i;
  logic [1:0]  fmt;
  logic        rb;
  logic [2:0]  order;
  logic [2:0]  lmap;
  logic [2:0]  depth;
  logic [11:0] y_lo, y_hi, c_lo, c_hi;
  logic        vld_o;
  logic [47:0] pix_o;

  int n_chk = 0;
  int n_err = 0;

  pix_fmt_out dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .vld_i      (vld_i),
    .pix_i      (pix_i),
    .fmt_i      (fmt),
    .rb_swap_i  (rb),
    .order_i    (order),
    .lane_map_i (lmap),
    .depth_i    (depth),
    .y_lo_i     (y_lo),
    .y_hi_i     (y_hi),
    .c_lo_i     (c_lo),
    .c_hi_i     (c_hi),
    .vld_o      (vld_o),
    .pix_o      (pix_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] gen(input int b, input int k);
    logic [11:0] a0, a1, a2;
    a0 = 12'((b + k) * 1237 + 5);
    a1 = 12'((b + k) * 2711 + 3000);
    a2 = 12'((b * 3 + k) * 911 + 77);
    return {a0, a1, a2};
  endfunction

  function automatic logic [11:0] lim(input logic [11:0] v, input logic [11:0] lo, input logic [11:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [15:0] fitm(input logic [11:0] v);
    case (depth)
      3'd1:    return {6'b0, v[11:2]};
      3'd2:    return {4'b0, v};
      3'd3:    return {v, 4'b0};
      default: return {8'b0, v[11:4]};
    endcase
  endfunction

  // expected output from the requirements
  function automatic logic [47:0] model(input logic [35:0] px, input logic par);
    logic [11:0] c [3];
    logic [11:0] p [3];
    logic [11:0] l [3];
    logic [11:0] t, yv, cv;
    logic [2:0]  ord;
    logic [47:0] r;
    for (int k = 0; k < 3; k++) c[k] = px[(2-k)*12 +: 12];
    if (fmt == 2'd2 || (fmt != 2'd1 && rb)) begin
      t = c[0]; c[0] = c[2]; c[2] = t;
    end
    if (fmt == 2'd1 || fmt == 2'd2) begin
      c[1] = lim(c[1], y_lo, y_hi);
      c[0] = lim(c[0], c_lo, c_hi);
      c[2] = lim(c[2], c_lo, c_hi);
    end
    ord = (fmt == 2'd2) ? 3'd0 : (fmt == 2'd1) ? 3'd5 : order;
    case (ord)
      3'd1:    p = '{c[1], c[2], c[0]};
      3'd2:    p = '{c[2], c[0], c[1]};
      3'd3:    p = '{c[0], c[2], c[1]};
      3'd4:    p = '{c[1], c[0], c[2]};
      3'd5:    p = '{c[2], c[1], c[0]};
      default: p = '{c[0], c[1], c[2]};
    endcase
    yv = p[1];
    cv = (fmt == 2'd2) ? (par ? p[0] : p[2]) : p[0];
    case (lmap)
      3'd1:    l = par ? '{yv, cv, 12'd0} : '{cv, yv, 12'd0};
      3'd2:    l = par ? '{cv, yv, 12'd0} : '{yv, cv, 12'd0};
      3'd3:    l = '{cv, yv, 12'd0};
      3'd4:    l = '{yv, cv, 12'd0};
      default: l = p;
    endcase
    for (int k = 0; k < 3; k++) r[(2-k)*16 +: 16] = fitm(l[k]);
    return r;
  endfunction

  // drive a burst of n pixels and check each result 3 cycles later (R2)
  task automatic burst(input string req, input int b, input int n);
    logic [47:0] ex [16];
    for (int k = 0; k <= n + 3; k++) begin
      @(negedge clk);
      if (k >= 3 && k - 3 < n) begin
        chk({req, " vld"}, {47'b0, vld_o}, 48'd1);
        chk(req, pix_o, ex[k-3]);
      end
      if (k == n + 3) begin
        chk({req, " R2 idle vld"}, {47'b0, vld_o}, 48'd0);
        chk({req, " R2 idle data"}, pix_o, 48'd0);
      end
      if (k < n) begin
        pix_i = gen(b, k);
        ex[k] = model(pix_i, k[0]);
        vld_i = 1'b1;
      end else begin
        vld_i = 1'b0;
        pix_i = 36'hFFF_FFF_FFF;
      end
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    vld_i  = 1'b1;
    pix_i  = 36'hABC_DEF_123;
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", {47'b0, vld_o}, 48'd0);
    chk("R1 data in reset", pix_o, 48'd0);
    vld_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 vld after reset", {47'b0, vld_o}, 48'd0);
    chk("R1 data after reset", pix_o, 48'd0);
  endtask

  task automatic t_latency;
    fmt = 2'd0; rb = 1'b0; order = 3'd0; lmap = 3'd0; depth = 3'd2;
    @(negedge clk);
    vld_i = 1'b1;
    pix_i = 36'h123_456_789;
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      vld_i = 1'b0;
      chk("R2 latency vld", {47'b0, vld_o}, (j == 3) ? 48'd1 : 48'd0);
      if (j == 3) chk("R2 latency data", pix_o, 48'h0123_0456_0789);
    end
  endtask

  task automatic t_rgb;
    fmt = 2'd0; rb = 1'b0; order = 3'd0; lmap = 3'd0; depth = 3'd2;
    y_lo = 12'h300; y_hi = 12'hA00; c_lo = 12'h300; c_hi = 12'hA00;
    burst("R3 rgb no clamp", 1, 8);
    rb = 1'b1;
    burst("R3 rgb swap", 2, 6);
    fmt = 2'd3; order = 3'd3;
    burst("R3 code3 as rgb", 3, 6);
  endtask

  task automatic t_orders;
    fmt = 2'd0; rb = 1'b0; lmap = 3'd0; depth = 3'd2;
    for (int o = 0; o < 8; o++) begin
      order = 3'(o);
      burst("R4 order", 10 + o, 3);
    end
  endtask

  task automatic t_clamp;
    fmt = 2'd1; rb = 1'b0; order = 3'd0; lmap = 3'd0; depth = 3'd3;
    y_lo = 12'h200; y_hi = 12'hD00; c_lo = 12'h100; c_hi = 12'h800;
    burst("R5 clamp 444", 20, 12);
    fmt = 2'd2;
    burst("R5 clamp 422", 21, 8);
  endtask

  task automatic t_444;
    fmt = 2'd1; rb = 1'b1; order = 3'd2; lmap = 3'd0; depth = 3'd2;
    y_lo = 12'h010; y_hi = 12'hFE0; c_lo = 12'h010; c_hi = 12'hFE0;
    burst("R6 444 overrides", 30, 6);
  endtask

  task automatic t_422;
    fmt = 2'd2; rb = 1'b0; order = 3'd4; depth = 3'd2;
    lmap = 3'd4;
    burst("R7 422 yc", 40, 6);
    lmap = 3'd0;
    burst("R7 422 pass", 41, 4);
    lmap = 3'd1;
    burst("R10 first burst", 42, 5);
    burst("R10 restart parity", 43, 4);
  endtask

  task automatic t_lanemap;
    fmt = 2'd2; rb = 1'b0; order = 3'd0; depth = 3'd2;
    for (int m = 0; m < 8; m++) begin
      lmap = 3'(m);
      burst("R8 lane map 422", 50 + m, 4);
    end
    fmt = 2'd1; lmap = 3'd3;
    burst("R8 lane map 444", 60, 3);
  endtask

  task automatic t_depth;
    fmt = 2'd0; rb = 1'b0; order = 3'd0; lmap = 3'd0;
    for (int d = 0; d < 8; d++) begin
      depth = 3'(d);
      burst("R9 depth", 70 + d, 3);
    end
  endtask

  initial begin
    fmt = 2'd0; rb = 1'b0; order = 3'd0; lmap = 3'd0; depth = 3'd2;
    y_lo = 12'h010; y_hi = 12'hFE0; c_lo = 12'h010; c_hi = 12'hFE0;
    vld_i = 1'b0; pix_i = '0; rst_ni = 1'b0;
    t_reset();
    t_latency();
    t_rgb();
    t_orders();
    t_clamp();
    t_444();
    t_422();
    t_lanemap();
    t_depth();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule